// File: doc/BRIEF.md
# Sleep-Mode Sequencer for a Synchronous Memory

This block controls how a synchronous memory goes into and comes out of a low-power sleep state. The request for sleep comes in on a pin that is asynchronous to the memory clock. The block first passes that pin through a flop synchronizer. It then steps through a short, fixed sequence on the way into sleep and another on the way out. While the sequence runs and while the memory sleeps, it holds the memory's access path closed.

In normal operation the memory is served while `access_en` is high. Sleep entry starts once the synchronized request is high. Entry lasts two cycles, and after that `asleep` is raised. When the request falls, the block spends two cycles recovering before it opens access again. During those recovery cycles, and at any other time that access is closed, every chip select and address strobe must stay low.

A select or strobe that arrives while access is closed raises a violation flag. The flag stays set until the next reset. This marks that a pending or early access cannot be trusted. The block does no power gating and keeps no array contents.

Top module: `sleep_ctrl`

## Requirements
- R1: `sleep_req` goes through two clock flops. A change on the pin that is driven between edges has no effect on `access_en` or `asleep` until the third rising edge after the change.
- R2: While reset is applied, and right after it is released, `access_en`=1, `asleep`=0 and `violation`=0. A request held low leaves the block active.
- R3: The entry phase lasts exactly two cycles. With the request high, `access_en` falls at the third rising edge and `asleep` rises at the fifth.
- R4: The exit phase lasts exactly two cycles. With the request low, `asleep` falls at the third rising edge and `access_en` rises at the fifth. During the exit phase both outputs are 0.
- R5: `asleep` and `access_en` are never high together.
- R6: If any bit of `chip_sel` or `addr_stb` is 1 at a rising edge while `access_en` is 0, `violation` is 1 after that edge. From then on it stays 1 until reset.
- R7: Selects and strobes seen while `access_en` is 1 do not set `violation`.
- R8: If the request falls during the entry phase, entry still completes and `asleep` is high for one cycle. The full two-cycle exit phase follows.
- R9: If the request rises during the exit phase, the exit still completes and `access_en` is high for one cycle. A new entry phase follows.
- R10: While the synchronized request stays high after entry, `asleep` stays 1 and `access_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, high means sleep |
| chip_sel | input | SEL_W | Active-high chip enables |
| addr_stb | input | STB_W | Active-high address strobes |
| asleep | output | 1 | Memory is in the sleep state |
| access_en | output | 1 | Accesses may be served |
| violation | output | 1 | Sticky flag for an access while access was closed |

## Verification
A phase counter or state that is off by one shows up at the ports as `access_en` or `asleep` changing one edge early or late. The bench sees that within five cycles of a request change. A missing synchronizer stage moves every transition one edge earlier. A wrong violation condition shows one cycle after the offending select, as a flag that is set or left clear wrongly. Because the flag is sticky, the error then persists until reset.

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int SEL_W       = 3,
  parameter int STB_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [SEL_W-1:0] chip_sel,
  input  logic [STB_W-1:0] addr_stb,
  output logic             asleep,
  output logic             access_en,
  output logic             violation
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

  typedef enum logic [1:0] {ACTIVE, ENTERING, SLEEP, EXITING} phase_t;

  logic [SYNC_STAGES-1:0] sync_q;
  phase_t                 phase_q;
  logic [CW-1:0]          cnt_q;
  logic                   viol_q;

  wire req_s = sync_q[SYNC_STAGES-1];
  wire touch = (|chip_sel) | (|addr_stb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ACTIVE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        ACTIVE:
          if (req_s) begin
            phase_q <= ENTERING;
            cnt_q   <= '0;
          end
        ENTERING:
          if (cnt_q == ENTER_LAST) phase_q <= SLEEP;
          else                     cnt_q   <= cnt_q + 1'b1;
        SLEEP:
          if (!req_s) begin
            phase_q <= EXITING;
            cnt_q   <= '0;
          end
        EXITING:
          if (cnt_q == EXIT_LAST) phase_q <= ACTIVE;
          else                    cnt_q   <= cnt_q + 1'b1;
        default: phase_q <= ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_q | ((phase_q != ACTIVE) & touch);

  assign asleep    = (phase_q == SLEEP);
  assign access_en = (phase_q == ACTIVE);
  assign violation = viol_q;
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter int STB_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] chip_sel,
  input logic [STB_W-1:0] addr_stb,
  input logic             asleep,
  input logic             access_en,
  input logic             violation
);
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(asleep && access_en)); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R6
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_en && ((|chip_sel) || (|addr_stb))) |=> violation); // R6
  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (access_en && !violation) |=> !violation); // R7
  AST_ENTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (!$past(access_en) && !$past(access_en, 2) && !$past(asleep, 2))); // R3
  AST_EXIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> (!$past(asleep) && !$past(asleep, 2) && !$past(access_en, 2))); // R4
  AST_WAKE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !access_en); // R4
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.SEL_W(SEL_W), .STB_W(STB_W)) u_chk (.*);

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;
  localparam int SEL_W = 3;
  localparam int STB_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [SEL_W-1:0] chip_sel = '0;
  logic [STB_W-1:0] addr_stb = '0;
  logic asleep, access_en, violation;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_ctrl #(.SEL_W(SEL_W), .STB_W(STB_W)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .chip_sel(chip_sel), .addr_stb(addr_stb),
    .asleep(asleep), .access_en(access_en), .violation(violation));

  // reference: 0 active, 1 entering, 2 sleep, 3 exiting
  int m_ph, m_left;
  bit m_p1, m_p2, m_v;

  function automatic bit exp_asleep(int ph); return ph == 2; endfunction
  function automatic bit exp_access(int ph); return ph == 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_p1 <= 0; m_p2 <= 0; m_v <= 0;
    end else begin
      m_p1 <= sleep_req;
      m_p2 <= m_p1;
      if (m_ph != 0 && (chip_sel != 0 || addr_stb != 0)) m_v <= 1;
      if (m_ph == 0 && m_p2)       begin m_ph <= 1; m_left <= 2; end
      else if (m_ph == 2 && !m_p2) begin m_ph <= 3; m_left <= 2; end
      else if (m_ph == 1 || m_ph == 3) begin
        if (m_left == 1) m_ph <= (m_ph == 1) ? 2 : 0;
        m_left <= m_left - 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sleep_req = 0; chip_sel = '0; addr_stb = '0;
    tick(2); rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    tick(2);
    chk("R2 reset access_en", access_en, 1);
    chk("R2 reset asleep", asleep, 0);
    chk("R2 reset violation", violation, 0);
    rst_n = 1;
    tick(5);
    chk("R2 idle access_en", access_en, 1);

    // R7: selects while active
    chip_sel = 3'b101; addr_stb = 2'b11; tick(3);
    chip_sel = '0; addr_stb = '0; tick(1);
    chk("R7 no violation while active", violation, 0);

    // R1/R3 entry timing
    sleep_req = 1;
    tick(2); chk("R1 no effect after 2 edges", access_en, 1);
    tick(1); chk("R3 access_en low at edge 3", access_en, 0);
    tick(1); chk("R3 still entering at edge 4", asleep, 0);
    tick(1); chk("R3 asleep at edge 5", asleep, 1);
    tick(20); chk("R10 held asleep", asleep, 1);
    chk("R10 held closed", access_en, 0);

    // R4 exit timing
    sleep_req = 0;
    tick(2); chk("R1 asleep unchanged after 2 edges", asleep, 1);
    tick(1); chk("R4 asleep falls at edge 3", asleep, 0);
    chk("R4 access closed in exit", access_en, 0);
    tick(1); chk("R4 access closed at edge 4", access_en, 0);
    tick(1); chk("R4 access_en at edge 5", access_en, 1);

    // R8 drop during entry
    sleep_req = 1; tick(3);
    chk("R8 entering", access_en, 0);
    sleep_req = 0;
    tick(2); chk("R8 entry completes", asleep, 1);
    tick(1); chk("R8 exit begins", asleep, 0);
    chk("R8 exit closed", access_en, 0);
    tick(2); chk("R8 exit completes", access_en, 1);
    tick(3);

    // R9 rise during exit
    sleep_req = 1; tick(5);
    chk("R9 asleep before", asleep, 1);
    sleep_req = 0; tick(3);
    chk("R9 exiting", access_en, 0);
    sleep_req = 1;
    tick(2); chk("R9 exit completes", access_en, 1);
    tick(1); chk("R9 re-entry", access_en, 0);
    tick(2); chk("R9 asleep again", asleep, 1);

    // R6 select while asleep, sticky
    chk("R6 clean before", violation, 0);
    addr_stb = 2'b10; tick(1); addr_stb = '0;
    chk("R6 set", violation, 1);
    sleep_req = 0; tick(10);
    chk("R6 sticky after wake", violation, 1);
    do_reset(); tick(1);
    chk("R6 cleared by reset", violation, 0);

    // R6 select during recovery window
    sleep_req = 1; tick(8); sleep_req = 0; tick(4);
    chk("R6 in exit window", access_en, 0);
    chip_sel = 3'b010; tick(1); chip_sel = '0;
    chk("R6 set in recovery", violation, 1);
    do_reset(); tick(1);

    // random against reference
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 19) == 0) sleep_req = ~sleep_req;
      if ($urandom_range(0, 15) == 0) begin
        chip_sel = SEL_W'($urandom); addr_stb = STB_W'($urandom);
      end else begin
        chip_sel = '0; addr_stb = '0;
      end
      if ($urandom_range(0, 299) == 0) rst_n = 0; else rst_n = 1;
      tick(1);
      chk("R3/R4/R1 asleep vs model", asleep, exp_asleep(m_ph));
      chk("R5/R8/R9 access_en vs model", access_en, exp_access(m_ph));
      chk("R6/R7 violation vs model", violation, m_v);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule